// File: doc/BRIEF.md
# Dual-Source Timing Divider Chain

This block is a binary ripple divider built entirely from clock-enable ticks inside a single synchronous clock domain. Two one-cycle tick inputs feed it. The high-frequency tick runs a four-state machine-cycle counter (S0 to S3), and that counter's wrap feeds stage one of the chain. The low-frequency tick can be injected directly into stage seven. Every stage's count bit is brought out as a tap, so timers and peripherals elsewhere can watch whichever rate they need.

Three things choose what drives stage seven: a system-clock-select input, a dual-clock-mode strap, and a one-bit source-select register that can be written. Stage seven takes either the fast-side carry, which is fc/256, or the slow tick. While the system runs from the slow tick, stages one to six are frozen at their current values. They resume counting from those values when the fast clock is selected again.

The machine-cycle counter is a four-state machine: MC_S0 -> MC_S1 -> MC_S2 -> MC_S3 -> MC_S0. It moves one state on each system-clock tick. The stage-seven source register is a two-state machine with states SRC_FAST and SRC_SLOW. Its ENGAGE transition goes from SRC_FAST to SRC_SLOW, and its RELEASE transition goes from SRC_SLOW back to SRC_FAST.

Top module: `dual_timing_divider`

## Requirements
- R1: While `rst` is high at a clock edge, all taps become 0, `mc_state` becomes 0, the source-select bit becomes 0 and the stage-seven source becomes the fast side.
- R2: `mc_state` encodes S0..S3 as 0..3. It advances by one on every system-clock tick and wraps from 3 to 0. The system-clock tick is `fc_tick` when `sys_sel`=0 and `fs_tick` when `sys_sel`=1.
- R3: Stage one receives a tick when `fc_tick`=1, `sys_sel`=0 and `mc_state`=3. Tap bit k-1 is the count bit of stage k. Therefore `taps[5:0]` counts stage-one ticks modulo 64, and `taps[NUM_STAGES-1:6]` counts stage-seven ticks modulo 2^(NUM_STAGES-6).
- R4: With `dual_mode`=0 and `sys_sel`=0, stage seven is driven by the fast carry whatever the select bit holds. The fast carry is a stage-one tick arriving while `taps[5:0]`=63. In this state `fs_tick` has no effect on the taps.
- R5: With `dual_mode`=1, `sys_sel`=0 and the select bit at 0, stage seven uses the fast carry and `fs_tick` has no effect on the taps.
- R6: With `dual_mode`=1, `sys_sel`=0 and the select bit at 1, stage seven counts `fs_tick` and ignores the fast carry. Stages one to six keep counting.
- R7: With `sys_sel`=1, stage seven counts `fs_tick` regardless of `dual_mode` and the select bit.
- R8: While `sys_sel`=1, `taps[5:0]` hold their value. They resume counting from that value once `sys_sel` returns to 0.
- R9: The select bit takes the value of `sel_wdata` at an edge where `sel_wr`=1 and keeps its value otherwise.
- R10: The source choice made from the inputs and select bit of cycle t governs the stage-seven tick of cycle t+1. In the cycle of a change, the previous source still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| fc_tick | input | 1 | One-cycle high-frequency tick |
| fs_tick | input | 1 | One-cycle low-frequency tick, already synchronous |
| sys_sel | input | 1 | System clock select: 0 fast side, 1 slow side |
| dual_mode | input | 1 | Strap: 1 dual-clock mode, 0 single-clock mode |
| sel_wr | input | 1 | Write strobe for the stage-seven source-select bit |
| sel_wdata | input | 1 | Value to write: 0 fast carry, 1 slow tick |
| taps | output | NUM_STAGES | Count bit of every divider stage, stage one in bit 0 |
| mc_state | output | 2 | Machine-cycle state, 0..3 for S0..S3 |

## Verification
Ticks and select writes presented in cycle t change `mc_state`, the taps and the select bit at the edge that closes cycle t. The bench samples those outputs in the middle of cycle t+1, before it drives new inputs. A change of stage-seven source shows only one cycle later, so the behavioural model in the bench keeps the source chosen in the previous cycle and applies it to the current tick. The model is compared with `mc_state`, the lower six taps and the upper taps on every clock. Tick patterns are chosen so that slow and fast ticks coincide with source switches, carries and the S3-to-S0 wrap.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    typedef enum logic [1:0] {
        MC_S0 = 2'd0,
        MC_S1 = 2'd1,
        MC_S2 = 2'd2,
        MC_S3 = 2'd3
    } mc_state_t;

    typedef enum logic {
        SRC_FAST = 1'b0,
        SRC_SLOW = 1'b1
    } src_state_t;

endpackage

// File: rtl/tdc_mcycle.sv
module tdc_mcycle
    import tdc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sys_tick,
    output mc_state_t state,
    output logic      wrap
);

    mc_state_t state_q;
    mc_state_t state_d;

    // next-state process
    always_comb begin
        state_d = state_q;
        if (sys_tick) begin
            unique case (state_q)
                MC_S0: state_d = MC_S1;
                MC_S1: state_d = MC_S2;
                MC_S2: state_d = MC_S3;
                MC_S3: state_d = MC_S0;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= MC_S0;
        else     state_q <= state_d;
    end

    // outputs
    always_comb begin
        state = state_q;
        wrap  = sys_tick && (state_q == MC_S3);
    end

    p_mc_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (sys_tick && state_q == MC_S3) |=> (state_q == MC_S0))
        else $error("R2: machine cycle did not wrap to S0");

    p_mc_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !sys_tick |=> $stable(state_q))
        else $error("R2: machine cycle moved without a tick");

endmodule

// File: rtl/tdc_stage.sv
module tdc_stage (
    input  logic clk,
    input  logic rst,
    input  logic tick_in,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst)          q <= 1'b0;
        else if (tick_in) q <= ~q;
    end

    p_stage_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !tick_in |=> $stable(q))
        else $error("R3: stage changed without an input tick");

    p_stage_flip_r3: assert property (@(posedge clk) disable iff (rst)
        tick_in |=> (q != $past(q)))
        else $error("R3: stage ignored an input tick");

endmodule

// File: rtl/tdc_src_sel.sv
module tdc_src_sel
    import tdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sys_sel,
    input  logic       dual_mode,
    input  logic       sel_bit,
    output src_state_t src
);

    src_state_t src_q;
    src_state_t src_d;
    logic       want_slow;

    assign want_slow = sys_sel || (dual_mode && sel_bit);

    // next-state process: ENGAGE (FAST->SLOW), RELEASE (SLOW->FAST)
    always_comb begin
        src_d = src_q;
        unique case (src_q)
            SRC_FAST: if (want_slow)  src_d = SRC_SLOW;
            SRC_SLOW: if (!want_slow) src_d = SRC_FAST;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) src_q <= SRC_FAST;
        else     src_q <= src_d;
    end

    // outputs
    always_comb src = src_q;

    p_slow_forced_r7: assert property (@(posedge clk) disable iff (rst)
        sys_sel |=> (src_q == SRC_SLOW))
        else $error("R7: slow system clock did not force slow source");

    p_single_fast_r4: assert property (@(posedge clk) disable iff (rst)
        (!dual_mode && !sys_sel) |=> (src_q == SRC_FAST))
        else $error("R4: single-clock mode did not force fast source");

endmodule

// File: rtl/dual_timing_divider.sv
module dual_timing_divider
    import tdc_pkg::*;
#(
    parameter int NUM_STAGES   = 21,
    parameter int INJECT_STAGE = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fc_tick,
    input  logic                  fs_tick,
    input  logic                  sys_sel,
    input  logic                  dual_mode,
    input  logic                  sel_wr,
    input  logic                  sel_wdata,
    output logic [NUM_STAGES-1:0] taps,
    output logic [1:0]            mc_state
);

    localparam int LOW_N = INJECT_STAGE - 1;

    mc_state_t             mc_q;
    src_state_t            src;
    logic                  sys_tick;
    logic                  mc_wrap;
    logic                  st1_tick;
    logic                  s7_tick;
    logic                  sel_bit;
    logic [NUM_STAGES-1:0] carry;
    logic [NUM_STAGES-1:0] taps_q;

    assign sys_tick = sys_sel ? fs_tick : fc_tick;

    tdc_mcycle u_mcycle (
        .clk      (clk),
        .rst      (rst),
        .sys_tick (sys_tick),
        .state    (mc_q),
        .wrap     (mc_wrap)
    );

    // stage one only sees the fast side; frozen while slow clock runs
    assign st1_tick = mc_wrap && !sys_sel;
    assign carry[0] = st1_tick;

    always_ff @(posedge clk) begin
        if (rst)         sel_bit <= 1'b0;
        else if (sel_wr) sel_bit <= sel_wdata;
    end

    tdc_src_sel u_src (
        .clk       (clk),
        .rst       (rst),
        .sys_sel   (sys_sel),
        .dual_mode (dual_mode),
        .sel_bit   (sel_bit),
        .src       (src)
    );

    assign s7_tick = (src == SRC_SLOW) ? fs_tick : carry[LOW_N];

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        logic tin;
        if (g == LOW_N) begin : g_inject
            assign tin = s7_tick;
        end else begin : g_chain
            assign tin = carry[g];
        end
        if (g < NUM_STAGES - 1) begin : g_carry
            assign carry[g+1] = tin && taps_q[g];
        end
        tdc_stage u_stage (
            .clk     (clk),
            .rst     (rst),
            .tick_in (tin),
            .q       (taps_q[g])
        );
    end

    assign taps     = taps_q;
    assign mc_state = mc_q;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (taps_q == '0 && mc_q == MC_S0 && !sel_bit && src == SRC_FAST))
        else $error("R1: reset did not clear the chain");

    p_freeze_low_r8: assert property (@(posedge clk) disable iff (rst)
        sys_sel |=> $stable(taps_q[LOW_N-1:0]))
        else $error("R8: low stages moved on slow clock");

    p_fast_src_r5: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_FAST && !carry[LOW_N]) |=> $stable(taps_q[LOW_N]))
        else $error("R5: stage seven moved without fast carry");

    p_slow_src_r6: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_SLOW && !fs_tick) |=> $stable(taps_q[LOW_N]))
        else $error("R6: stage seven moved without slow tick");

    p_sel_write_r9: assert property (@(posedge clk) disable iff (rst)
        sel_wr |=> (sel_bit == $past(sel_wdata)))
        else $error("R9: select bit not written");

endmodule

// File: tb/test_dual_timing_divider.sv
`timescale 1ns/1ps
module test_dual_timing_divider;

    localparam int NS    = 21;
    localparam int LOWN  = 6;
    localparam int HIMOD = 1 << (NS - LOWN);

    logic          clk = 1'b0;
    logic          rst, fc_tick, fs_tick, sys_sel, dual_mode, sel_wr, sel_wdata;
    logic [NS-1:0] taps;
    logic [1:0]    mc_state;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    string tag = "R1";

    // behavioural reference state
    int m_ms = 0, m_low = 0, m_high = 0;
    bit m_sel = 0, m_src_slow = 0;

    always #2 clk = ~clk;

    dual_timing_divider #(.NUM_STAGES(NS), .INJECT_STAGE(7)) i_dual_timing_divider (
        .clk(clk), .rst(rst), .fc_tick(fc_tick), .fs_tick(fs_tick),
        .sys_sel(sys_sel), .dual_mode(dual_mode), .sel_wr(sel_wr),
        .sel_wdata(sel_wdata), .taps(taps), .mc_state(mc_state)
    );

    task automatic compare();
        checks++;
        if (int'(mc_state) != m_ms) begin
            errors++;
            $display("FAIL %s mc_state actual=%0d expected=%0d", tag, mc_state, m_ms);
        end
        checks++;
        if (int'(taps[LOWN-1:0]) != m_low) begin
            errors++;
            $display("FAIL %s low taps actual=%0d expected=%0d", tag, taps[LOWN-1:0], m_low);
        end
        checks++;
        if (int'(taps[NS-1:LOWN]) != m_high) begin
            errors++;
            $display("FAIL %s high taps actual=%0d expected=%0d", tag, taps[NS-1:LOWN], m_high);
        end
    endtask

    // one clock: check outputs mid-cycle, drive inputs, advance the model
    task automatic step(bit r, bit fc, bit fs, bit ss, bit dm, bit we, bit wd);
        bit systick, st1, s7, fc256;
        @(negedge clk);
        compare();
        rst = r; fc_tick = fc; fs_tick = fs; sys_sel = ss;
        dual_mode = dm; sel_wr = we; sel_wdata = wd;
        if (r) begin
            m_ms = 0; m_low = 0; m_high = 0; m_sel = 0; m_src_slow = 0;
        end else begin
            systick = ss ? fs : fc;
            st1     = fc && !ss && (m_ms == 3);
            fc256   = st1 && (m_low == 63);
            s7      = m_src_slow ? fs : fc256;
            if (systick) m_ms = (m_ms + 1) % 4;
            if (st1)     m_low = (m_low + 1) % 64;
            if (s7)      m_high = (m_high + 1) % HIMOD;
            m_src_slow = ss || (dm && m_sel);
            if (we) m_sel = wd;
        end
    endtask

    // fc_mode: 0 none, 1 every cycle, 2 two of three; fs every fs_per cycles (0 never)
    task automatic run(int n, bit ss, bit dm, int fc_mode, int fs_per);
        for (int i = 0; i < n; i++) begin
            bit fc, fs;
            fc = (fc_mode == 1) || (fc_mode == 2 && (i % 3) != 1);
            fs = (fs_per != 0) && ((i % fs_per) == 0);
            step(1'b0, fc, fs, ss, dm, 1'b0, 1'b0);
        end
    endtask

    task automatic write_sel(bit ss, bit dm, bit wd, bit fs);
        step(1'b0, 1'b1, fs, ss, dm, 1'b1, wd);
    endtask

    initial begin
        rst = 1; fc_tick = 0; fs_tick = 0; sys_sel = 0;
        dual_mode = 0; sel_wr = 0; sel_wdata = 0;
        @(negedge clk);
        tag = "R1";
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        tag = "R2";  run(23, 0, 0, 1, 0);
        tag = "R3";  run(700, 0, 0, 2, 0);
        tag = "R9";  write_sel(0, 0, 1, 1);
        tag = "R4";  run(1500, 0, 0, 1, 2);
        tag = "R9";  write_sel(0, 1, 0, 1);
        tag = "R5";  run(1100, 0, 1, 1, 2);
        tag = "R10"; write_sel(0, 1, 1, 1);
        run(3, 0, 1, 1, 1);
        tag = "R6";  run(1100, 0, 1, 1, 5);
        tag = "R10"; write_sel(0, 1, 0, 1);
        run(3, 0, 1, 1, 1);
        tag = "R8";  run(300, 0, 1, 2, 0);
        tag = "R7";  run(300, 1, 0, 1, 3);
        tag = "R7";  run(300, 1, 1, 1, 4);
        tag = "R8";  run(600, 0, 1, 1, 0);
        tag = "R1";  step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        run(2, 0, 1, 0, 1);
        tag = "R5";  run(200, 0, 1, 1, 2);
        @(negedge clk);
        compare();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired in %s", tag);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule